// File: doc/BRIEF.md
# Packed Lane Saturating Adder/Subtractor

This block adds or subtracts two 32-bit words that are split into independent lanes. The word is treated either as four 8-bit unsigned lanes or as two 16-bit signed lanes. Each lane is computed separately, and no carry crosses a lane boundary.

For plain add and subtract, a lane result that falls outside the lane's range can be clamped to the nearest limit, or it can be allowed to wrap. In both cases an out-of-range lane sets a sticky overflow bit in a 32-bit control word. The halving variants return the full-precision sum or difference shifted right by one. Optional rounding adds one before the shift, and these variants never raise overflow.

The control word can be loaded from a dedicated write port. All of its bits other than the overflow bit are kept as they are unless that port loads them. The result and the control word change only on a clock edge: the result when an operation is presented, the control word when an operation is presented or the write port is used.

Top module: `simd_addsub`

## Requirements
- R1: While `rst_n` is low, `result` and `ctl_reg` are both zero.
- R2: Lane i occupies bits [n*(i+1)-1 : n*i], with lane 0 least significant. `fmt`=0 selects four 8-bit unsigned lanes (n=8) and `fmt`=1 selects two 16-bit signed lanes (n=16). No carry or borrow passes between lanes.
- R3: In the 16-bit signed format with `sat_en`=1, an add or subtract lane result above 32767 becomes 0x7FFF, and one below -32768 becomes 0x8000.
- R4: In the 8-bit unsigned format with `sat_en`=1, an add or subtract lane result above 255 becomes 0xFF, and one below 0 becomes 0x00.
- R5: With `sat_en`=0, an add or subtract writes the low n bits of the exact lane result. An out-of-range lane still sets the overflow bit.
- R6: The halving opcodes are `opcode`=2 (add-half) and 3 (subtract-half); `opcode`=0 is add and 1 is subtract. With `rnd_en`=0, a halving lane result is the low n bits of (a±b)>>1, where a±b is computed exactly and the shift is arithmetic.
- R7: With `rnd_en`=1, a halving lane result is the low n bits of (a±b+1)>>1, computed exactly.
- R8: Halving opcodes never set the overflow bit, even when the exact value does not fit in n bits.
- R9: The overflow bit is bit 20 of `ctl_reg`. Once set, it stays set until the write port loads a value in which that bit is 0. An operation leaves every other bit of `ctl_reg` unchanged.
- R10: When `ctl_wr_en`=1, `ctl_reg` takes `ctl_wr_data` at the next edge. If an overflowing operation is accepted in the same cycle, bit 20 is also set at that edge.
- R11: `result` and bit 20 of `ctl_reg` update only at an edge where `in_valid`=1; otherwise `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operation at this edge |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand (subtrahend) |
| opcode | input | 2 | 0 add, 1 subtract, 2 add-half, 3 subtract-half |
| fmt | input | 1 | 0: four 8-bit unsigned lanes, 1: two 16-bit signed lanes |
| sat_en | input | 1 | Clamp out-of-range add/subtract lanes |
| rnd_en | input | 1 | Round halving results |
| ctl_wr_en | input | 1 | Load the control word |
| ctl_wr_data | input | 32 | Value loaded into the control word |
| result | output | 32 | Registered packed result |
| ctl_reg | output | 32 | Control word, overflow at bit 20 |

## Verification
The embedded properties assume that every input is a known 0 or 1 at each rising edge and that reset is held low for at least one edge before it is released. The properties relate `result` and `ctl_reg` to the inputs sampled one edge earlier. The stimulus changes inputs only on falling edges and never leaves a control input undriven. The overlap of a control-word write with an accepted operation is driven on purpose, because bit 20 then depends on both.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_ADDH = 2'd2,
    OP_SUBH = 2'd3
  } lane_op_e;

  typedef enum logic {
    FMT_QUAD_U8  = 1'b0,
    FMT_DUAL_S16 = 1'b1
  } lane_fmt_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W           = 8,
  parameter bit SIGNED_LANE = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  input  logic         halve,
  input  logic         sat_en,
  input  logic         rnd_en,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] HI_LIM = SIGNED_LANE ?
      {3'b000, {(W-1){1'b1}}} : {2'b00, {W{1'b1}}};
  localparam logic signed [EW-1:0] LO_LIM = SIGNED_LANE ?
      {3'b111, {(W-1){1'b0}}} : {EW{1'b0}};

  logic signed [EW-1:0] ext_a, ext_b, exact;
  logic                 above, below;

  always_comb begin
    ext_a = SIGNED_LANE ? {{2{a[W-1]}}, a} : {2'b00, a};
    ext_b = SIGNED_LANE ? {{2{b[W-1]}}, b} : {2'b00, b};
    exact = is_sub ? (ext_a - ext_b) : (ext_a + ext_b);
    above = exact > HI_LIM;
    below = exact < LO_LIM;
  end

  always_comb begin
    if (halve) begin
      res = W'((exact[W:0] + {{W{1'b0}}, rnd_en}) >> 1);
      ovf = 1'b0;
    end else begin
      ovf = above | below;
      if (sat_en && above)      res = HI_LIM[W-1:0];
      else if (sat_en && below) res = LO_LIM[W-1:0];
      else                      res = exact[W-1:0];
    end
  end
endmodule

// File: rtl/simd_ctl_reg.sv
module simd_ctl_reg #(
  parameter int CTL_W   = 32,
  parameter int OVF_BIT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             set_ovf,
  output logic [CTL_W-1:0] ctl_q
);
  localparam logic [CTL_W-1:0] OVF_MASK = CTL_W'(1) << OVF_BIT;

  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = wr_en ? wr_data : ctl_q;
    if (set_ovf) ctl_d = ctl_d | OVF_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctl_q <= '0;
    else if (wr_en || set_ovf)  ctl_q <= ctl_d;
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[OVF_BIT] && !wr_en) |=> ctl_q[OVF_BIT]);

  a_r9_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((ctl_q & ~OVF_MASK) == $past(ctl_q & ~OVF_MASK)));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_ovf) |=> (ctl_q == $past(wr_data)));

  a_r10_load_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && set_ovf) |=> (ctl_q == ($past(wr_data) | OVF_MASK)));
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int HALF_W  = 16,
  parameter int OVF_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        opcode,
  input  logic              fmt,
  input  logic              sat_en,
  input  logic              rnd_en,
  input  logic              ctl_wr_en,
  input  logic [DATA_W-1:0] ctl_wr_data,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] ctl_reg
);
  import simd_pkg::*;

  localparam int NB = DATA_W / BYTE_W;
  localparam int NH = DATA_W / HALF_W;

  lane_op_e          op;
  lane_fmt_e         lane_fmt;
  logic              is_sub, halve;
  logic [DATA_W-1:0] byte_res, half_res, res_d;
  logic [NB-1:0]     byte_ovf;
  logic [NH-1:0]     half_ovf;
  logic              lane_ovf, set_ovf;

  always_comb begin
    op       = lane_op_e'(opcode);
    lane_fmt = lane_fmt_e'(fmt);
    is_sub   = (op == OP_SUB) || (op == OP_SUBH);
    halve    = (op == OP_ADDH) || (op == OP_SUBH);
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane #(.W(BYTE_W), .SIGNED_LANE(1'b0)) u_lane (
      .a      (op_a[BYTE_W*i +: BYTE_W]),
      .b      (op_b[BYTE_W*i +: BYTE_W]),
      .is_sub (is_sub),
      .halve  (halve),
      .sat_en (sat_en),
      .rnd_en (rnd_en),
      .res    (byte_res[BYTE_W*i +: BYTE_W]),
      .ovf    (byte_ovf[i])
    );
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    simd_lane #(.W(HALF_W), .SIGNED_LANE(1'b1)) u_lane (
      .a      (op_a[HALF_W*i +: HALF_W]),
      .b      (op_b[HALF_W*i +: HALF_W]),
      .is_sub (is_sub),
      .halve  (halve),
      .sat_en (sat_en),
      .rnd_en (rnd_en),
      .res    (half_res[HALF_W*i +: HALF_W]),
      .ovf    (half_ovf[i])
    );
  end

  always_comb begin
    if (lane_fmt == FMT_DUAL_S16) begin
      res_d    = half_res;
      lane_ovf = |half_ovf;
    end else begin
      res_d    = byte_res;
      lane_ovf = |byte_ovf;
    end
    set_ovf = in_valid && lane_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result <= '0;
    else if (in_valid) result <= res_d;
  end

  simd_ctl_reg #(.CTL_W(DATA_W), .OVF_BIT(OVF_BIT)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .set_ovf (set_ovf),
    .ctl_q   (ctl_reg)
  );

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r8_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[1] && !ctl_wr_en && !ctl_reg[OVF_BIT])
      |=> !ctl_reg[OVF_BIT]);

  a_r11_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !ctl_wr_en) |=> $stable(ctl_reg));
endmodule

// File: tb/simd_addsub_test.sv
module simd_addsub_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic [1:0]  opcode;
  logic        fmt, sat_en, rnd_en, ctl_wr_en;
  logic [31:0] ctl_wr_data;
  logic [31:0] result, ctl_reg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  simd_addsub uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .fmt(fmt), .sat_en(sat_en), .rnd_en(rnd_en),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .result(result), .ctl_reg(ctl_reg)
  );

  // {opcode[2], fmt, sat, rnd, exp_ovf, a[32], b[32], exp_result[32]}
  localparam int NV = 16;
  localparam logic [101:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,1'b0,1'b0, 32'h01020304, 32'h10203040, 32'h11223344}, // R2
    {2'd0,1'b0,1'b0,1'b0,1'b1, 32'h000000FF, 32'h00000001, 32'h00000000}, // R2 R5
    {2'd0,1'b0,1'b1,1'b0,1'b1, 32'h80FF0010, 32'h80020005, 32'hFFFF0015}, // R4
    {2'd1,1'b0,1'b1,1'b0,1'b1, 32'h05100000, 32'h0A080001, 32'h00080000}, // R4
    {2'd1,1'b0,1'b0,1'b0,1'b1, 32'h00000000, 32'h00000001, 32'h000000FF}, // R5
    {2'd0,1'b1,1'b1,1'b0,1'b1, 32'h7FFF8000, 32'h00018000, 32'h7FFF8000}, // R3
    {2'd1,1'b1,1'b1,1'b0,1'b1, 32'h80007FFF, 32'h0001FFFF, 32'h80007FFF}, // R3
    {2'd0,1'b1,1'b0,1'b0,1'b1, 32'h7FFF0001, 32'h00010002, 32'h80000003}, // R5
    {2'd0,1'b1,1'b1,1'b0,1'b0, 32'h1234FFFF, 32'h11110001, 32'h23450000}, // R2
    {2'd2,1'b0,1'b0,1'b0,1'b0, 32'hFF030201, 32'hFF000001, 32'hFF010101}, // R6 R8
    {2'd2,1'b0,1'b0,1'b1,1'b0, 32'hFF030201, 32'hFF000001, 32'hFF020101}, // R7
    {2'd3,1'b0,1'b0,1'b0,1'b0, 32'h00000010, 32'h00000204, 32'h0000FF06}, // R6
    {2'd2,1'b1,1'b1,1'b0,1'b0, 32'h7FFF8000, 32'h7FFF8000, 32'h7FFF8000}, // R8
    {2'd2,1'b1,1'b0,1'b1,1'b0, 32'h7FFFFFFF, 32'h7FFF0000, 32'h7FFF0000}, // R7
    {2'd3,1'b1,1'b0,1'b1,1'b0, 32'h00030000, 32'h00000001, 32'h00020000}, // R7
    {2'd3,1'b1,1'b0,1'b0,1'b0, 32'h00000000, 32'h00000001, 32'h0000FFFF}  // R6
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; ctl_wr_en = 1'b0;
  endtask

  task automatic ctl_write(logic [31:0] d);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = d; in_valid = 1'b0;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic run_op(logic [1:0] o, logic f, logic s, logic r,
                        logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    opcode = o; fmt = f; sat_en = s; rnd_en = r; op_a = a; op_b = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; idle_inputs();
    op_a = 32'hDEADBEEF; op_b = 32'h12345678; opcode = 2'd0; fmt = 1'b0;
    sat_en = 1'b0; rnd_en = 1'b0; ctl_wr_data = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, 32'h0);
    check("R1 ctl in reset", ctl_reg, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [101:0] v;
      v = VEC[i];
      ctl_write(32'h0);
      run_op(v[101:100], v[99], v[98], v[97], v[95:64], v[63:32]);
      check($sformatf("table %0d result", i), result, v[31:0]);
      check($sformatf("table %0d ovf bit", i), {31'h0, ctl_reg[20]},
            {31'h0, v[96]});
    end

    // R11: inputs presented without in_valid leave result and flag untouched
    ctl_write(32'h0);
    run_op(2'd0, 1'b0, 1'b0, 1'b0, 32'h01010101, 32'h01010101);
    @(negedge clk);
    opcode = 2'd0; fmt = 1'b0; op_a = 32'hFF000000; op_b = 32'hFF000000;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 result held", result, 32'h02020202);
    check("R11 flag untouched", ctl_reg, 32'h0);

    // R9: sticky flag, other bits preserved
    ctl_write(32'h000000A5);
    run_op(2'd0, 1'b0, 1'b1, 1'b0, 32'h000000FF, 32'h00000001);
    check("R9 flag set, others kept", ctl_reg, 32'h001000A5);
    check("R4 clamp lane0", result, 32'h000000FF);
    run_op(2'd0, 1'b0, 1'b0, 1'b0, 32'h00000001, 32'h00000001);
    check("R9 flag sticky after clean op", ctl_reg, 32'h001000A5);
    check("R9 clean op result", result, 32'h00000002);
    run_op(2'd3, 1'b1, 1'b0, 1'b0, 32'h80000000, 32'h7FFF0000);
    check("R8 halving keeps ctl", ctl_reg, 32'h001000A5);
    check("R6 signed subh", result, 32'h80000000);

    // R10: write clears sticky bit
    ctl_write(32'h0);
    check("R10 write clears flag", ctl_reg, 32'h0);

    // R10: write and overflowing op in the same cycle
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = 32'h12240000;
    opcode = 2'd1; fmt = 1'b1; sat_en = 1'b1; rnd_en = 1'b0;
    op_a = 32'h00008000; op_b = 32'h00000001; in_valid = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R10 write plus overflow", ctl_reg, 32'h12340000);
    check("R3 clamp to minimum", result, 32'h00008000);

    // R10: write with no op, then R8 halving on a clear flag
    ctl_write(32'h00000003);
    run_op(2'd2, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R8 halving no flag", ctl_reg, 32'h00000003);
    check("R7 byte rounding at top", result, 32'hFFFFFFFF);

    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 result after reset", result, 32'h0);
    check("R1 ctl after reset", ctl_reg, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule